// File: doc/BRIEF.md
# Multi-Clock Frequency Meter

The block measures the rate of five unrelated clocks at once, each against one free-running status clock. A timer in the status domain marks off fixed gate windows. Each monitored clock drives its own free-running edge counter. That counter is carried into the status domain as a Gray-coded value. At every window boundary the status logic takes the difference between the current snapshot and the one taken at the previous boundary. That difference is the number of monitored edges seen in the window. The block publishes it as a 32-bit read-only result.

With the default gate of 100,000 status cycles and a 100 MHz status clock, a one-millisecond window gives a result equal to the monitored frequency in kHz. If the status clock runs at some other rate F (in MHz), the true frequency is the reading times F divided by 100. Software does that rescale; the block does not.

The five results are read through a small select port. Select values 0 to 4 address consecutive result slots. Slot 0 is the reference clock, slot 1 the RX MAC clock, slot 2 the TX MAC clock, slot 3 the RX recovered clock and slot 4 the TX serializer clock.

Top module: `freq_meter`

## Requirements
- R1: Each published result equals the number of rising edges of its monitored clock within one gate window of GATE_CYCLES status cycles, within a tolerance of plus or minus 1.
- R2: Gate windows are exactly GATE_CYCLES status cycles long and repeat back to back from reset release. Results change only on the status edge that ends a window, so the first publish happens on the 2*GATE_CYCLES-th status edge after reset release.
- R3: The channels are independent. rd_sel values 0, 1, 2, 3 and 4 return the results for mon_clk bits 0, 1, 2, 3 and 4 respectively (reference, RX MAC, TX MAC, RX recovered, TX serializer). Any rd_sel value of 5 or above returns zero.
- R4: A result updates at most once per window and holds its value, unchanged, between window boundaries.
- R5: Each counter crosses into the status domain only as a Gray code. The transferred value changes by at most one bit per monitored clock edge.
- R6: While rst_n is low, and from release until the first publish, every result reads zero. The first boundary after reset only primes the snapshot and publishes nothing.
- R7: A monitored clock that stops reads zero after one full window with no edges. It never keeps its previous value.
- R8: A change of a monitored clock's frequency appears in its result no later than the end of the second full window after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_status | input | 1 | Free-running status clock; defines the gate windows |
| rst_n | input | 1 | Synchronous active-low reset, status domain (re-timed into each monitored domain) |
| mon_clk | input | NUM_CLKS (5) | Monitored clocks, one per channel |
| rd_sel | input | SEL_W (3) | Result slot select |
| rd_data | output | CNT_W (32) | Selected result, edge count per window; zero for an unused slot |

## Verification
There are three ways a broken internal state shows at the ports. A gate timer with the wrong length scales every slot by the same wrong factor, and this is visible at the first publish, two windows after reset. A snapshot that is not refreshed, or a delta that is not cleared, leaves a stopped clock reading its old value. It also makes a retimed clock read wrong. Both stay wrong one to two windows after the change. A slip in the read mux or in the reset priming shows at once, as a swapped slot or as a non-zero reading before the second boundary.

// File: rtl/fm_pkg.sv
// Package: shared width and Gray-code helpers for the frequency meter.
// Assumes counts are modular; widths come from CNT_W.
package fm_pkg;
    localparam int unsigned CNT_W = 32;

    // Binary to reflected Gray code.
    function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        for (int i = 0; i < CNT_W; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction
endpackage

// File: rtl/fm_gate_timer.sv
// Gate timer: a strobe marks the last status cycle of every window.
// Assumes GATE_CYCLES >= 2; windows start at reset release.
module fm_gate_timer #(
    parameter int unsigned GATE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);
    localparam int unsigned GW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

    logic [GW-1:0] cnt;

    // Count status cycles, wrapping at the end of each window.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign win_end = (cnt == LAST);

    // Checker state: status cycles since the previous strobe.
    logic [31:0] gap;
    logic        seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else begin
            gap  <= win_end ? 32'd0 : gap + 32'd1;
            seen <= seen | win_end;
        end
    end

    // R2: strobes are spaced by exactly one window.
    a_r2_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && seen) |-> (gap == GATE_CYCLES - 1));
    // R2: a strobe lasts a single cycle.
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> !win_end);
endmodule

// File: rtl/fm_edge_counter.sv
// Edge counter: free-running count of monitored clock edges, held as a
// registered Gray code for transfer. Reset is re-timed into this domain.
// Assumes the monitored clock runs while reset is released.
module fm_edge_counter
    import fm_pkg::*;
(
    input  logic             mon_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_out
);
    logic [1:0]       rst_sync;
    logic [CNT_W-1:0] bin;

    // Re-time the status-domain reset into the monitored domain.
    always_ff @(posedge mon_clk) rst_sync <= {rst_sync[0], rst_n};

    // Count edges and keep a glitch-free registered Gray copy.
    always_ff @(posedge mon_clk) begin
        if (!rst_sync[1]) begin
            bin      <= '0;
            gray_out <= '0;
        end else begin
            bin      <= bin + 1'b1;
            gray_out <= bin2gray(bin + 1'b1);
        end
    end

    // R5: the transferred code moves by at most one bit per edge.
    a_r5_gray_step: assert property (@(posedge mon_clk) disable iff (!rst_sync[1])
        $countones(gray_out ^ $past(gray_out)) <= 1);
endmodule

// File: rtl/fm_snapshot.sv
// Snapshot: brings a Gray count into the status domain, and at each window
// end publishes the edges counted since the previous end. The first end
// after reset only primes. Assumes win_end comes from the status-domain timer.
module fm_snapshot
    import fm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    input  logic             win_end,
    output logic [CNT_W-1:0] result
);
    logic [CNT_W-1:0] sync1, sync2, sync2_d, prev;
    logic             primed, moved;
    logic [CNT_W-1:0] cur;
    logic             chg;

    // Two-stage synchronizer, plus a delayed copy for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1   <= '0;
            sync2   <= '0;
            sync2_d <= '0;
        end else begin
            sync1   <= gray_in;
            sync2   <= sync1;
            sync2_d <= sync2;
        end
    end

    assign cur = gray2bin(sync2);
    assign chg = (sync2 != sync2_d);

    // Capture at each boundary; publish the delta once primed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev   <= '0;
            primed <= 1'b0;
            result <= '0;
        end else if (win_end) begin
            prev   <= cur;
            primed <= 1'b1;
            if (primed) result <= cur - prev;
        end
    end

    // Checker state: any movement of the synchronized code this window.
    always_ff @(posedge clk) begin
        if (!rst_n)       moved <= 1'b0;
        else if (win_end) moved <= 1'b0;
        else              moved <= moved | chg;
    end

    // R4: the result moves only on a window end.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(result));
    // R6: reset clears the result.
    a_r6_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (result == '0));
    // R6: an unprimed boundary publishes nothing.
    a_r6_prime_only: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !primed) |=> (result == '0));
    // R7: a window with no movement publishes zero.
    a_r7_stopped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && primed && !moved && !chg) |=> (result == '0));
endmodule

// File: rtl/freq_meter.sv
// Multi-clock frequency meter top: one gate timer, one counter and one
// snapshot per monitored clock, and a result select. Assumes mon_clk bits
// are unrelated to clk_status and to each other.
module freq_meter
    import fm_pkg::*;
#(
    parameter int unsigned NUM_CLKS    = 5,
    parameter int unsigned GATE_CYCLES = 100000,
    localparam int unsigned SEL_W      = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
    input  logic                clk_status,
    input  logic                rst_n,
    input  logic [NUM_CLKS-1:0] mon_clk,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [CNT_W-1:0]    rd_data
);
    logic             win_end;
    logic [CNT_W-1:0] gray_w [NUM_CLKS];
    logic [CNT_W-1:0] res_w  [NUM_CLKS];

    fm_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
        .clk     (clk_status),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    for (genvar i = 0; i < NUM_CLKS; i++) begin : g_ch
        fm_edge_counter u_cnt (
            .mon_clk  (mon_clk[i]),
            .rst_n    (rst_n),
            .gray_out (gray_w[i])
        );
        fm_snapshot u_snap (
            .clk     (clk_status),
            .rst_n   (rst_n),
            .gray_in (gray_w[i]),
            .win_end (win_end),
            .result  (res_w[i])
        );
    end

    // Select a result slot; unused slot codes read zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CLKS; i++) begin
            if (int'(rd_sel) == i) rd_data = res_w[i];
        end
    end

    // R3: an unused slot code returns zero.
    a_r3_unused_zero: assert property (@(posedge clk_status) disable iff (!rst_n)
        (int'(rd_sel) >= NUM_CLKS) |-> (rd_data == '0));
endmodule

// File: tb/sim_freq_meter.sv
`timescale 1ns/1ps
module sim_freq_meter;
    localparam int GATE = 200;
    localparam int N    = 5;

    logic          clk_status = 1'b0;
    logic          rst_n      = 1'b0;
    logic [N-1:0]  mon_clk    = '0;
    logic [2:0]    rd_sel     = '0;
    logic [31:0]   rd_data;

    real half [N] = '{4.0, 5.0, 8.0, 12.5, 3.2};
    bit  run  [N] = '{1, 1, 1, 1, 1};

    int applied = 0;
    int fails   = 0;
    int cyc     = 0;
    bit done    = 0;

    typedef struct { int sel; int exp; int tol; string tag; } item_t;
    item_t sbq[$];

    freq_meter #(.NUM_CLKS(N), .GATE_CYCLES(GATE)) u0 (
        .clk_status (clk_status),
        .rst_n      (rst_n),
        .mon_clk    (mon_clk),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data)
    );

    always #10 clk_status = ~clk_status;   // 50 MHz
    always begin #(half[0]); if (run[0]) mon_clk[0] = ~mon_clk[0]; end
    always begin #(half[1]); if (run[1]) mon_clk[1] = ~mon_clk[1]; end
    always begin #(half[2]); if (run[2]) mon_clk[2] = ~mon_clk[2]; end
    always begin #(half[3]); if (run[3]) mon_clk[3] = ~mon_clk[3]; end
    always begin #(half[4]); if (run[4]) mon_clk[4] = ~mon_clk[4]; end

    // Status edges counted since reset release.
    always @(posedge clk_status) if (rst_n) cyc <= cyc + 1;

    // Expected edges per window for a given monitored half period (ns).
    function automatic int edges(real h);
        return int'($floor(GATE * 20.0 / (2.0 * h) + 0.5));
    endfunction

    // Driver: queue one expectation.
    task automatic push(int sel, int exp, int tol, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tol = tol; it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: pop each expectation, read its slot and compare.
    task automatic drain();
        while (sbq.size() > 0) begin
            item_t it = sbq.pop_front();
            @(negedge clk_status);
            rd_sel = it.sel[2:0];
            #1;
            applied++;
            if (int'(rd_data) < it.exp - it.tol || int'(rd_data) > it.exp + it.tol) begin
                fails++;
                $display("FAIL %s sel=%0d actual=%0d expected=%0d+/-%0d",
                         it.tag, it.sel, rd_data, it.exp, it.tol);
            end
        end
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk_status);
    endtask

    initial begin
        int snap [N];
        repeat (5) @(negedge clk_status);
        // R6: results are zero while in reset.
        for (int i = 0; i < N; i++) push(i, 0, 0, "R6 in reset");
        drain();
        rst_n = 1'b1;

        // R6: still zero just before the first publish.
        wait_cyc(2*GATE - 8);
        for (int i = 0; i < 3; i++) push(i, 0, 0, "R6 before first publish");
        drain();

        // R2: first publish on edge 2*GATE.
        wait_cyc(2*GATE + 3);
        push(1, edges(half[1]), 1, "R2 first publish");
        drain();

        // R1/R3: every slot with its own rate.
        wait_cyc(4*GATE + 10);
        for (int i = 0; i < N; i++) push(i, edges(half[i]), 1, "R1 R3 rate per slot");
        drain();

        // R3: unused slot codes read zero.
        for (int s = N; s < 8; s++) push(s, 0, 0, "R3 unused slot");
        drain();

        // R4: values hold within a window.
        wait_cyc(5*GATE + 10);
        for (int i = 0; i < N; i++) begin
            @(negedge clk_status);
            rd_sel = 3'(i);
            #1 snap[i] = int'(rd_data);
        end
        wait_cyc(5*GATE + 120);
        for (int i = 0; i < N; i++) push(i, snap[i], 0, "R4 hold in window");
        drain();

        // R7/R8: stop slot 0, slow slot 2, mid-window.
        wait_cyc(6*GATE + 10);
        run[0]  = 0;
        half[2] = 20.0;
        wait_cyc(8*GATE + 10);
        push(0, 0, 0, "R7 stopped clock");
        push(2, edges(20.0), 1, "R8 retimed clock");
        push(1, edges(half[1]), 1, "R1 unaffected neighbour");
        push(4, edges(half[4]), 1, "R1 unaffected neighbour");
        drain();

        // R7: stays zero a window later.
        wait_cyc(9*GATE + 10);
        push(0, 0, 0, "R7 stays zero");
        drain();

        // R6: reset again mid-run clears all slots.
        @(negedge clk_status);
        rst_n = 1'b0;
        repeat (3) @(negedge clk_status);
        for (int i = 1; i < N; i++) push(i, 0, 0, "R6 reset clears");
        drain();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk_status);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end
endmodule